// File: doc/BRIEF.md
# DMA Remapping Global Command Controller

This block holds the global command and status logic of an I/O address-remapping unit. Software programs it through a 32-bit register port with three registers. The first is a write-only command register that triggers actions. The second is a read-only status register that reports when those actions have finished. The third holds the address of the root table. The block acts on two commands. One turns remapping on or off. The other copies the programmed root-table address into the active pointer that the translation hardware uses.

DMA traffic passes through a valid/ready accept handshake and a completion pulse. An internal counter uses these to track how many transactions are still in flight. When a command is accepted, the block stops taking new DMA requests and waits for the counter to reach zero. It then applies the command in a single cycle and reopens the DMA port. As a result, every transaction runs entirely in one mode. While a pointer copy is pending, the root-pointer status bit reads 0.

Top module: `remap_gcmd_ctrl`

## Requirements
- R1: After reset, remap_en is 0, root_ptr is 0, the status register (offset 0x1C) reads 0 and dma_req_ready is 1.
- R2: The command register (offset 0x18) always reads 0. A command write with bit 30 at 0 and bit 31 equal to the current enable status changes nothing.
- R3: Writing 1 to bit 30 of the command register copies the root-table address register into root_ptr and sets status bit 30. With nothing in flight, both changes are visible after the second clock edge counted from the write.
- R4: Writing bit 31 of the command register sets the remap mode: 1 turns remapping on and 0 turns it off. Status bit 31 equals remap_en. With nothing in flight, the change is visible after the second clock edge counted from the write.
- R5: remap_en and root_ptr change only in a cycle that follows one with zero transactions in flight. While a command is pending, dma_req_ready is 0.
- R6: A command accepted while transactions are in flight completes only after the last of them has signalled completion.
- R7: An enable command is ignored when no pointer copy has completed since reset or since the last disable. In that case remap_en and status bit 31 stay 0.
- R8: A single write with both bit 31 and bit 30 set performs the pointer copy first and then the enable, so the write succeeds even with no earlier copy.
- R9: dma_req_ready is 0 while the in-flight count equals MAX_OUT, and it returns to 1 once a completion arrives.
- R10: Command writes that arrive while a command is still pending are ignored.
- R11: The root-table address register (offset 0x20) can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe, data returned in the same cycle |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, 0 when no read |
| dma_req_valid | input | 1 | DMA request offered |
| dma_req_ready | output | 1 | DMA request accepted when high together with valid |
| dma_cpl | input | 1 | One in-flight DMA transaction completes |
| remap_en | output | 1 | Remapping active |
| root_ptr | output | PTR_W | Active root-table pointer |

## Verification
The assertions check several rules on every cycle. The mode and the pointer change only at a point where nothing is in flight. A mode never turns on without a completed pointer copy. The counter can neither overflow nor drop below zero. A written root-table address is held exactly. Other behaviours depend on a history of register writes and traffic, so only the bench scenarios can show them: draining before completion, discarding writes while a command is busy, ignoring an enable that has no pointer, and the combined write ordering. The bench checks these against a reference model in the testbench, using random command and traffic sequences together with directed cases.

// File: rtl/remap_gcmd_pkg.sv
package remap_gcmd_pkg;

  // Register byte offsets
  localparam logic [7:0] OFS_CMD = 8'h18;
  localparam logic [7:0] OFS_STS = 8'h1C;
  localparam logic [7:0] OFS_RTA = 8'h20;

  // Bit positions shared by command and status registers
  localparam int BIT_TE  = 31;
  localparam int BIT_RTP = 30;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_DRAIN = 1'b1
  } seq_state_e;

endpackage

// File: rtl/remap_reg_if.sv
module remap_reg_if
  import remap_gcmd_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int PTR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              sts_te,
  input  logic              sts_rtp,
  output logic [31:0]       rdata,
  output logic              cmd_wr,
  output logic              cmd_te,
  output logic              cmd_srtp,
  output logic [PTR_W-1:0]  rta
);

  localparam logic [REG_AW-1:0] A_CMD = REG_AW'(OFS_CMD);
  localparam logic [REG_AW-1:0] A_STS = REG_AW'(OFS_STS);
  localparam logic [REG_AW-1:0] A_RTA = REG_AW'(OFS_RTA);

  logic             hit_cmd, hit_sts, hit_rta;
  logic             rta_en;
  logic [PTR_W-1:0] rta_q, rta_d;

  assign hit_cmd = (addr == A_CMD);
  assign hit_sts = (addr == A_STS);
  assign hit_rta = (addr == A_RTA);

  // Command strobes toward the sequencer
  assign cmd_wr   = wr_en && hit_cmd;
  assign cmd_te   = wdata[BIT_TE];
  assign cmd_srtp = wdata[BIT_RTP];

  // Root-table address register
  assign rta_en = wr_en && hit_rta;
  assign rta_d  = wdata[PTR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rta_q <= '0;
    else if (rta_en) rta_q <= rta_d;
  end

  assign rta = rta_q;

  // Read mux; command register is write-only and reads zero
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit_sts) begin
        rdata[BIT_TE]  = sts_te;
        rdata[BIT_RTP] = sts_rtp;
      end else if (hit_rta) begin
        rdata = 32'(rta_q);
      end
    end
  end

  a_r11_rta_holds_write: assert property (@(posedge clk) disable iff (!rst_n)
    rta_en |=> (rta_q == $past(rta_d)));

endmodule

// File: rtl/remap_inflight_cnt.sv
module remap_inflight_cnt #(
  parameter int MAX_OUT = 15,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             empty,
  output logic             full
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec_ok;
  logic             cnt_en;

  // A completion with nothing outstanding is dropped
  assign dec_ok = dec && ((cnt_q != '0) || inc);
  assign cnt_en = inc ^ dec_ok;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec_ok)      cnt_d = cnt_q + 1'b1;
    else if (!inc && dec_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt   = cnt_q;
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_MAX);

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !inc) |=> empty);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !dec) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/remap_cmd_seq.sv
module remap_cmd_seq
  import remap_gcmd_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             cmd_te,
  input  logic             cmd_srtp,
  input  logic [PTR_W-1:0] rta,
  input  logic             cnt_empty,
  output logic             hold,
  output logic             te_sts,
  output logic             rtp_sts,
  output logic [PTR_W-1:0] act_ptr
);

  seq_state_e       state_q, state_d;
  logic             pend_ptr_q, pend_ptr_d;
  logic             pend_te_q, pend_te_d;
  logic             tgt_q, tgt_d;
  logic             te_q, te_d;
  logic             rtp_q, rtp_d;
  logic             pv_q, pv_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             te_chg, te_ok, te_go, accept_cmd, apply;

  // Decode of an incoming command
  assign te_chg     = (cmd_te != te_q);
  assign te_ok      = !cmd_te || pv_q || cmd_srtp;
  assign te_go      = te_chg && te_ok;
  assign accept_cmd = (state_q == SEQ_IDLE) && cmd_wr && (cmd_srtp || te_go);
  assign apply      = (state_q == SEQ_DRAIN) && cnt_empty;

  always_comb begin
    state_d    = state_q;
    pend_ptr_d = pend_ptr_q;
    pend_te_d  = pend_te_q;
    tgt_d      = tgt_q;
    te_d       = te_q;
    rtp_d      = rtp_q;
    pv_d       = pv_q;
    ptr_d      = ptr_q;
    if (accept_cmd) begin
      state_d    = SEQ_DRAIN;
      pend_ptr_d = cmd_srtp;
      pend_te_d  = te_go;
      tgt_d      = cmd_te;
      if (cmd_srtp) rtp_d = 1'b0;
    end else if (apply) begin
      state_d    = SEQ_IDLE;
      pend_ptr_d = 1'b0;
      pend_te_d  = 1'b0;
      // Pointer copy is ordered before the mode change
      if (pend_ptr_q) begin
        ptr_d = rta;
        rtp_d = 1'b1;
        pv_d  = 1'b1;
      end
      if (pend_te_q) begin
        te_d = tgt_q;
        if (!tgt_q) pv_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      pend_ptr_q <= 1'b0;
      pend_te_q  <= 1'b0;
      tgt_q      <= 1'b0;
      te_q       <= 1'b0;
      rtp_q      <= 1'b0;
      pv_q       <= 1'b0;
      ptr_q      <= '0;
    end else begin
      state_q    <= state_d;
      pend_ptr_q <= pend_ptr_d;
      pend_te_q  <= pend_te_d;
      tgt_q      <= tgt_d;
      te_q       <= te_d;
      rtp_q      <= rtp_d;
      pv_q       <= pv_d;
      ptr_q      <= ptr_d;
    end
  end

  assign hold    = (state_q == SEQ_DRAIN);
  assign te_sts  = te_q;
  assign rtp_sts = rtp_q;
  assign act_ptr = ptr_q;

  a_r5_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(te_q) |-> $past(cnt_empty));

  a_r3_ptr_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_q) |-> ($past(cnt_empty) && rtp_q));

  a_r7_enable_needs_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te_q) |-> rtp_q);

  a_r5_hold_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SEQ_IDLE) && cmd_wr && cmd_srtp) |=> hold);

endmodule

// File: rtl/remap_gcmd_ctrl.sv
module remap_gcmd_ctrl
  import remap_gcmd_pkg::*;
#(
  parameter int REG_AW  = 8,
  parameter int PTR_W   = 32,
  parameter int MAX_OUT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dma_req_valid,
  output logic              dma_req_ready,
  input  logic              dma_cpl,
  output logic              remap_en,
  output logic [PTR_W-1:0]  root_ptr
);

  localparam int CNT_W = $clog2(MAX_OUT + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             cmd_wr, cmd_te, cmd_srtp;
  logic [PTR_W-1:0] rta;
  logic             hold, te_sts, rtp_sts;
  logic [CNT_W-1:0] cnt;
  logic             cnt_empty, cnt_full;
  logic             dma_acc;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  remap_reg_if #(.REG_AW(REG_AW), .PTR_W(PTR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (reg_wr_en),
    .rd_en    (reg_rd_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .sts_te   (te_sts),
    .sts_rtp  (rtp_sts),
    .rdata    (reg_rdata),
    .cmd_wr   (cmd_wr),
    .cmd_te   (cmd_te),
    .cmd_srtp (cmd_srtp),
    .rta      (rta)
  );

  remap_inflight_cnt #(.MAX_OUT(MAX_OUT)) u_cnt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .inc   (dma_acc),
    .dec   (dma_cpl),
    .cnt   (cnt),
    .empty (cnt_empty),
    .full  (cnt_full)
  );

  remap_cmd_seq #(.PTR_W(PTR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cmd_wr    (cmd_wr),
    .cmd_te    (cmd_te),
    .cmd_srtp  (cmd_srtp),
    .rta       (rta),
    .cnt_empty (cnt_empty),
    .hold      (hold),
    .te_sts    (te_sts),
    .rtp_sts   (rtp_sts),
    .act_ptr   (root_ptr)
  );

  assign dma_req_ready = !hold && !cnt_full;
  assign dma_acc       = dma_req_valid && dma_req_ready;
  assign remap_en      = te_sts;

  a_r9_full_blocks_accept: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cnt == CNT_W'(MAX_OUT)) |-> !dma_acc);

  a_r5_no_accept_while_pending: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(hold) |-> !dma_req_ready);

endmodule

// File: tb/remap_gcmd_ctrl_test.sv
module remap_gcmd_ctrl_test;

  localparam int B_MAX = 4;
  localparam logic [7:0] A_CMD = 8'h18;
  localparam logic [7:0] A_STS = 8'h1C;
  localparam logic [7:0] A_RTA = 8'h20;

  logic        clk, rst_n;
  logic        reg_wr_en, reg_rd_en;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        dma_req_valid, dma_req_ready, dma_cpl;
  logic        remap_en;
  logic [31:0] root_ptr;

  int n_chk, n_fail;

  // Reference model state
  bit          m_te, m_rtp, m_pv;
  logic [31:0] m_ptr, m_rta;
  int          m_out;

  remap_gcmd_ctrl #(.REG_AW(8), .PTR_W(32), .MAX_OUT(B_MAX)) uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready), .dma_cpl(dma_cpl),
    .remap_en(remap_en), .root_ptr(root_ptr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] exp_status(bit te, bit rtp);
    return {te, rtp, 30'd0};
  endfunction

  // Model a command write issued with nothing in flight
  function automatic void model_cmd(bit te, bit srtp);
    bit go;
    go = (te != m_te) && (!te || m_pv || srtp);
    if (srtp) begin
      m_ptr = m_rta;
      m_rtp = 1'b1;
      m_pv  = 1'b1;
    end
    if (go) begin
      m_te = te;
      if (!te) m_pv = 1'b0;
    end
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    reg_rd_en = 1'b0;
  endtask

  task automatic dma_accept(output bit took);
    @(negedge clk);
    dma_req_valid = 1'b1;
    took = dma_req_ready;
    @(negedge clk);
    dma_req_valid = 1'b0;
  endtask

  task automatic dma_complete();
    @(negedge clk);
    dma_cpl = 1'b1;
    @(negedge clk);
    dma_cpl = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    bit          took;
    n_chk = 0; n_fail = 0;
    reg_wr_en = 0; reg_rd_en = 0; reg_addr = 0; reg_wdata = 0;
    dma_req_valid = 0; dma_cpl = 0;
    m_te = 0; m_rtp = 0; m_pv = 0; m_ptr = 0; m_rta = 0; m_out = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 remap_en", 32'(remap_en), 32'd0);
    check("R1 root_ptr", root_ptr, 32'd0);
    check("R1 ready", 32'(dma_req_ready), 32'd1);
    reg_read(A_STS, rd); check("R1 status", rd, 32'd0);

    // R11 root-table address register
    reg_write(A_RTA, 32'h1234_5000); m_rta = 32'h1234_5000;
    reg_read(A_RTA, rd); check("R11 rta readback", rd, 32'h1234_5000);

    // R7 enable with no pointer
    reg_write(A_CMD, 32'h8000_0000); @(negedge clk);
    check("R7 remap_en", 32'(remap_en), 32'd0);
    reg_read(A_STS, rd); check("R7 status", rd, 32'd0);

    // R2 no-op write and read-as-zero
    reg_write(A_CMD, 32'h3FFF_FFFF); @(negedge clk);
    check("R2 root_ptr", root_ptr, 32'd0);
    reg_read(A_STS, rd); check("R2 status", rd, 32'd0);

    // R3 pointer copy
    reg_write(A_CMD, 32'h4000_0000); @(negedge clk);
    model_cmd(1'b0, 1'b1);
    check("R3 root_ptr", root_ptr, 32'h1234_5000);
    reg_read(A_STS, rd); check("R3 status", rd, exp_status(0, 1));
    reg_read(A_CMD, rd); check("R2 cmd reads zero", rd, 32'd0);

    // R4 enable
    reg_write(A_CMD, 32'h8000_0000);
    check("R4 not before apply edge", 32'(remap_en), 32'd0);
    @(negedge clk);
    model_cmd(1'b1, 1'b0);
    check("R4 remap_en", 32'(remap_en), 32'd1);
    reg_read(A_STS, rd); check("R4 status", rd, exp_status(1, 1));

    // R5/R6/R10 disable with traffic in flight
    for (int i = 0; i < 3; i++) begin
      dma_accept(took);
      if (took) m_out++;
    end
    check("R9 three accepted", 32'(m_out), 32'd3);
    reg_write(A_RTA, 32'hABCD_0000); m_rta = 32'hABCD_0000;
    reg_write(A_CMD, 32'h0000_0000);
    check("R5 ready low pending", 32'(dma_req_ready), 32'd0);
    dma_complete();
    reg_write(A_CMD, 32'h4000_0000);  // R10: dropped while busy
    dma_complete();
    check("R6 still on with 1 left", 32'(remap_en), 32'd1);
    dma_complete(); m_out = 0;
    check("R6 on until boundary", 32'(remap_en), 32'd1);
    @(negedge clk);
    model_cmd(1'b0, 1'b0);
    check("R6 off after drain", 32'(remap_en), 32'd0);
    check("R10 ptr unchanged", root_ptr, 32'h1234_5000);
    check("R5 ready back", 32'(dma_req_ready), 32'd1);

    // R7 re-enable without new copy
    reg_write(A_CMD, 32'h8000_0000); @(negedge clk);
    check("R7 re-enable ignored", 32'(remap_en), 32'd0);

    // R8 combined write
    reg_write(A_CMD, 32'hC000_0000); @(negedge clk);
    model_cmd(1'b1, 1'b1);
    check("R8 remap_en", 32'(remap_en), 32'd1);
    check("R8 root_ptr", root_ptr, 32'hABCD_0000);

    // R9 saturation
    for (int i = 0; i < B_MAX; i++) begin
      dma_accept(took);
      if (took) m_out++;
    end
    check("R9 ready low at max", 32'(dma_req_ready), 32'd0);
    dma_accept(took);
    check("R9 refused at max", 32'(took), 32'd0);
    dma_complete(); m_out--;
    check("R9 ready after cpl", 32'(dma_req_ready), 32'd1);
    while (m_out > 0) begin dma_complete(); m_out--; end

    // Random mix against the model
    void'($urandom(32'd20240611));
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 6;
      if (op == 0) begin
        logic [31:0] v;
        v = $urandom;
        reg_write(A_RTA, v); m_rta = v;
      end else if (op <= 2) begin
        if (m_out == 0) begin
          bit te, sp;
          te = 1'($urandom); sp = 1'($urandom);
          reg_write(A_CMD, {te, sp, 30'($urandom)});
          @(negedge clk);
          model_cmd(te, sp);
          check("R4 random remap_en", 32'(remap_en), 32'(m_te));
          check("R3 random root_ptr", root_ptr, m_ptr);
          reg_read(A_STS, rd); check("R4 random status", rd, exp_status(m_te, m_rtp));
        end else begin
          dma_complete(); m_out--;
        end
      end else if (op <= 4) begin
        check("R9 random ready", 32'(dma_req_ready), 32'(m_out < B_MAX));
        dma_accept(took);
        if (took) m_out++;
      end else if (m_out > 0) begin
        dma_complete(); m_out--;
      end
    end
    finish_run();
  end

endmodule